// File: doc/BRIEF.md
# Threshold-Interrupt Result Queue

This block sits between a custom producer that emits result words at a high rate and a CPU that collects them over a small memory-mapped register port. Words offered on a valid/data stream are stored in a first-in first-out buffer. The CPU reads a data register to remove the oldest word. It reads a status register for the fill level and the empty, full and overflow flags.

The CPU programs a fill threshold and an interrupt enable. Whenever the stored word count is at or above the threshold, the interrupt line is held high. The CPU can then remove words with back-to-back reads. The line is computed from the current count in every cycle rather than pulsed on an event. As a result, no request can be lost when the CPU removes words in the same cycles that the producer adds them.

Register offsets:

| Offset | Register | Contents |
|---|---|---|
| 0 | data | a read removes one word |
| 1 | status | count and flags |
| 2 | threshold | fill threshold |
| 3 | control | interrupt enable and flush |

Top module: `evq_fifo`

## Requirements
- R1: After reset, the count is 0 and the status register reads 0x0001_0000. That value is the empty flag at bit 16 with every other field clear. The threshold register and the control register read 0, and `irq` is low.
- R2: Words leave in the order they entered. A read of offset 0 puts the oldest word, zero-extended, on `bus_rdata` one cycle after the read strobe.
- R3: A word offered on `in_valid` is stored if the buffer is not full, whether words arrive every cycle or every other cycle. No word is lost until the buffer holds DEPTH words.
- R4: The status register reports the count in bits [LVL_W-1:0]. The count rises by one on a stored word and falls by one on a read of offset 0 from a non-empty buffer. A stored word and such a read in the same cycle leave the count unchanged.
- R5: Status bit 17 is the full flag. A word offered while the buffer is full is dropped and sets the overflow flag, status bit 18. The overflow flag stays set until a write to offset 1 with bit 18 set. When a set and a clear happen in the same cycle, the set wins.
- R6: A read of offset 0 while the buffer is empty returns 0 and does not change the count.
- R7: `irq` is high exactly when the enable bit (control bit 0) is set, the threshold is non-zero, and the count is at or above the threshold. It follows the count in the same cycle the count changes, including while reads and stored words happen together.
- R8: A threshold of 0 keeps `irq` low at any count.
- R9: A write to offset 3 with bit 1 set empties the buffer, and a word offered in that cycle is dropped. The flush leaves the threshold, the enable bit and the overflow flag as they were. Control bit 1 always reads back as 0.
- R10: Offset 2 holds the threshold in bits [LVL_W-1:0] and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a word this cycle |
| in_data | input | DATA_W | Producer word |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Threshold interrupt request |

## Verification
A stored word, a removed word or a register write changes the block's state at the clock edge where it is presented. The count, the flags and `irq` show the new value in the cycle after that edge, and `irq` needs no extra register stage. A read returns the state from before its own edge, and `bus_rdata` carries it from the following cycle. The bench drives every input on a falling edge and samples each output on the next falling edge. For status checks it issues a fresh read only after the operation under test has completed. During simultaneous fill and drain it checks `irq` and the removed word in every single cycle.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_THR  = 2'd2,
    REG_CTRL = 2'd3
  } evq_reg_e;

  localparam int STAT_EMPTY_BIT = 16;
  localparam int STAT_FULL_BIT  = 17;
  localparam int STAT_OVF_BIT   = 18;
  localparam int CTRL_IEN_BIT   = 0;
  localparam int CTRL_FLUSH_BIT = 1;
endpackage

// File: rtl/evq_store.sv
module evq_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
    end else begin
      if (push) wptr_d = wptr_q + AW'(1);
      if (pop)  rptr_d = rptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= wdata;
  end

  assign head = mem[rptr_q];
endmodule

// File: rtl/evq_level.sv
module evq_level #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [LVL_W-1:0] level_q, level_d;

  always_comb begin
    level_d = level_q;
    if (flush)              level_d = '0;
    else if (push && !pop)  level_d = level_q + LVL_W'(1);
    else if (pop && !push)  level_d = level_q - LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level = level_q;
  assign full  = (level_q == LVL_W'(DEPTH));
  assign empty = (level_q == '0);
endmodule

// File: rtl/evq_irq.sv
module evq_irq #(
  parameter int LVL_W = 5
) (
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thr,
  input  logic             ien,
  output logic             irq
);
  logic thr_armed;
  assign thr_armed = (thr != '0);
  assign irq = ien && thr_armed && (level >= thr);
endmodule

// File: rtl/evq_fifo.sv
module evq_fifo
  import evq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  evq_reg_e         reg_sel;
  logic [LVL_W-1:0] level, thr_q, thr_d;
  logic             full, empty;
  logic             ien_q, ien_d, ovf_q, ovf_d;
  logic             push, pop, flush, ovf_set, ovf_clr;
  logic [DATA_W-1:0] head;
  logic [31:0]      stat, rdata_d, rdata_q;
  logic             unused_wdata_bits;

  assign reg_sel = evq_reg_e'(bus_addr);
  assign flush   = bus_wr && (reg_sel == REG_CTRL) && bus_wdata[CTRL_FLUSH_BIT];
  assign pop     = bus_rd && (reg_sel == REG_DATA) && !empty;
  assign push    = in_valid && !full && !flush;
  assign ovf_set = in_valid && full;
  assign ovf_clr = bus_wr && (reg_sel == REG_STAT) && bus_wdata[STAT_OVF_BIT];
  assign unused_wdata_bits = ^bus_wdata;

  evq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .wdata(in_data), .head(head)
  );

  evq_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .level(level), .full(full), .empty(empty)
  );

  evq_irq #(.LVL_W(LVL_W)) u_irq (
    .level(level), .thr(thr_q), .ien(ien_q), .irq(irq)
  );

  always_comb begin
    thr_d = thr_q;
    ien_d = ien_q;
    if (bus_wr && reg_sel == REG_THR)  thr_d = bus_wdata[LVL_W-1:0];
    if (bus_wr && reg_sel == REG_CTRL) ien_d = bus_wdata[CTRL_IEN_BIT];
    ovf_d = ovf_set || (ovf_q && !ovf_clr);
  end

  always_comb begin
    stat = '0;
    stat[LVL_W-1:0]      = level;
    stat[STAT_EMPTY_BIT] = empty;
    stat[STAT_FULL_BIT]  = full;
    stat[STAT_OVF_BIT]   = ovf_q;
    unique case (reg_sel)
      REG_DATA: rdata_d = empty ? 32'd0 : 32'(head);
      REG_STAT: rdata_d = stat;
      REG_THR:  rdata_d = 32'(thr_q);
      REG_CTRL: rdata_d = 32'(ien_q);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q   <= '0;
      ien_q   <= 1'b0;
      ovf_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      thr_q <= thr_d;
      ien_q <= ien_d;
      ovf_q <= ovf_d;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/evq_fifo_chk.sv
module evq_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic [LVL_W-1:0] level,
  input logic [LVL_W-1:0] thr_q,
  input logic             ien_q,
  input logic             ovf_q,
  input logic             full,
  input logic             empty,
  input logic             irq
);
  logic rd_dat, flush_p, clr_p;
  assign rd_dat  = bus_rd && bus_addr == 2'd0;
  assign flush_p = bus_wr && bus_addr == 2'd3 && bus_wdata[1];
  assign clr_p   = bus_wr && bus_addr == 2'd1 && bus_wdata[18];

  a_r4_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  a_r4_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !full && rd_dat && !empty && !flush_p |=> level == $past(level));

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !clr_p |=> ovf_q);

  a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_dat && !flush_p |=> full);

  a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_dat && !in_valid |=> empty);

  a_r7_irq_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q && level >= thr_q));

  a_r8_thr_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q == '0 |-> !irq);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_p |=> empty && level == '0);
endmodule

bind evq_fifo evq_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bus_addr(bus_addr),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .level(level),
  .thr_q(thr_q), .ien_q(ien_q), .ovf_q(ovf_q), .full(full), .empty(empty),
  .irq(irq)
);

// File: tb/tb_evq_fifo.sv
`timescale 1ns/1ps
module tb_evq_fifo;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [DATA_W-1:0] in_data;
  logic [1:0]        bus_addr;
  logic              bus_rd, bus_wr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [DATA_W-1:0] model [$];

  always #5 clk = ~clk;

  evq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_exp(input int lvl, input bit ovf);
    logic [31:0] s = 32'(lvl);
    s[16] = (lvl == 0);
    s[17] = (lvl == DEPTH);
    s[18] = ovf;
    return s;
  endfunction

  task automatic push(input logic [DATA_W-1:0] v);
    in_valid = 1'b1; in_data = v;
    @(negedge clk);
    in_valid = 1'b0;
    if (model.size() < DEPTH) model.push_back(v);
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic check_status(input string req, input int lvl, input bit ovf);
    logic [31:0] d;
    bus_read(2'd1, d);
    check(req, d, stat_exp(lvl, ovf));
  endtask

  task automatic drain_all(input string req);
    logic [31:0] d;
    while (model.size() > 0) begin
      bus_read(2'd0, d);
      check(req, d, 32'(model.pop_front()));
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check_status("R1 status", 0, 1'b0);
    bus_read(2'd2, d); check("R1 threshold", d, 0);
    bus_read(2'd3, d); check("R1 control", d, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) begin
      push(16'hA000 + 16'(i));
      @(negedge clk);
    end
    check_status("R4 level after 5", 5, 1'b0);
    drain_all("R2 order");
    check_status("R4 level back to 0", 0, 1'b0);
  endtask

  task automatic t_rate();
    for (int i = 0; i < DEPTH / 2; i++) push(16'h1100 + 16'(i));
    for (int i = DEPTH / 2; i < DEPTH; i++) begin
      push(16'h1100 + 16'(i));
      @(negedge clk);
    end
    check_status("R3 full without loss", DEPTH, 1'b0);
    drain_all("R3 every word kept");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) push(16'h2200 + 16'(i));
    push(16'hDEAD);
    check_status("R5 overflow flag set", DEPTH, 1'b1);
    drain_all("R5 dropped word absent");
    check_status("R5 overflow sticky", 0, 1'b1);
    bus_write(2'd1, 32'h0004_0000);
    check_status("R5 write-1 clears", 0, 1'b0);
  endtask

  task automatic t_empty_read();
    logic [31:0] d;
    bus_read(2'd0, d);
    check("R6 empty read zero", d, 0);
    check_status("R6 level unchanged", 0, 1'b0);
  endtask

  task automatic t_push_pop();
    logic [31:0] d;
    push(16'h3301); push(16'h3302);
    in_valid = 1'b1; in_data = 16'h3303;
    bus_rd = 1'b1; bus_addr = 2'd0;
    @(negedge clk);
    in_valid = 1'b0; bus_rd = 1'b0;
    model.push_back(16'h3303);
    check("R4 simultaneous pop data", bus_rdata, 32'(model.pop_front()));
    check_status("R4 push+pop holds level", 2, 1'b0);
    drain_all("R2 after push+pop");
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(2'd2, 32'd4);
    bus_read(2'd2, d); check("R10 threshold readback", d, 4);
    bus_write(2'd3, 32'd1);
    for (int i = 0; i < 3; i++) push(16'h4400 + 16'(i));
    check("R7 below threshold", 32'(irq), 0);
    in_valid = 1'b1; in_data = 16'h4480;
    bus_rd = 1'b1; bus_addr = 2'd0;
    @(negedge clk);
    in_valid = 1'b0; bus_rd = 1'b0;
    model.push_back(16'h4480);
    check("R7 level 3 fill+drain low", 32'(irq), 0);
    check("R2 data during fill+drain", bus_rdata, 32'(model.pop_front()));
    push(16'h4403);
    check("R7 reaches threshold", 32'(irq), 1);
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_data = 16'h4500 + 16'(i);
      bus_rd = 1'b1; bus_addr = 2'd0;
      @(negedge clk);
      model.push_back(16'h4500 + 16'(i));
      check("R7 held during fill+drain", 32'(irq), 1);
      check("R2 data during fill+drain", bus_rdata, 32'(model.pop_front()));
    end
    in_valid = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R2 data on drain", bus_rdata, 32'(model.pop_front()));
    check("R7 drops below threshold", 32'(irq), 0);
    for (int i = 0; i < 5; i++) push(16'h4600 + 16'(i));
    check("R7 level 8 high", 32'(irq), 1);
    bus_write(2'd2, 32'd0);
    check("R8 threshold zero quiet", 32'(irq), 0);
    bus_write(2'd2, 32'd4);
    bus_write(2'd3, 32'd0);
    check("R7 enable off quiet", 32'(irq), 0);
    bus_write(2'd3, 32'd1);
    check("R7 enable on", 32'(irq), 1);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) push(16'h5500 + 16'(i));
    push(16'hBEEF);
    in_valid = 1'b1; in_data = 16'h5A5A;
    bus_write(2'd3, 32'h3);
    in_valid = 1'b0;
    model.delete();
    check_status("R9 flush empties, keeps ovf", 0, 1'b1);
    bus_read(2'd2, d); check("R9 threshold kept", d, 4);
    bus_read(2'd3, d); check("R9 flush bit reads 0", d, 1);
    check("R9 irq low after flush", 32'(irq), 0);
    bus_write(2'd1, 32'h0004_0000);
    check_status("R5 clear after flush", 0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_rate();
    t_overflow();
    t_empty_read();
    t_push_pop();
    t_irq();
    t_flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule